// File: doc/BRIEF.md
# Watchdog Heartbeat Extender

This block sits next to a per-core watchdog whose base period is short and whose escalation runs interrupt, then non-maskable interrupt, then chip reset, one base period per stage. It stretches that short period into a long heartbeat. Each time a core's watchdog raises its interrupt, the block either pokes the watchdog back to its start, or it stops answering. Once a core has used up its allowance of base periods, the block stops answering that core's interrupt. The watchdog then escalates on its own through its last two stages.

Configuration is a requested heartbeat in seconds and a longest base period in seconds. An iterative search picks the longest base period that divides the heartbeat exactly, and derives the reload count from it. A ping input, issued by software as a keep-alive, refills every core's count, pokes every core and re-arms any core that was silenced. A level input switches between plain always-poke operation and countdown operation.

Top module: `hb_extender`

## Requirements
- R1: After a configuration load, `period_o` settles to the largest value p ≤ max(`max_period_i`,1) with `heartbeat_i` mod p = 0.
- R2: The reload count is heartbeat/period − 2, or 0 when heartbeat/period ≤ 2. In countdown mode, a freshly reloaded core therefore answers exactly that many interrupt edges with pokes.
- R3: In countdown mode, an interrupt edge on an enabled core whose count is nonzero pulses that core's `poke_o` bit for one cycle, in the cycle after the edge is sampled, and decrements the count.
- R4: In countdown mode, an interrupt edge on an enabled core with count zero produces no poke and clears that core's `en_mask_o` bit. While that bit is 0, the core's interrupts produce no poke.
- R5: With countdown mode off, every interrupt edge on an enabled core produces a poke, whatever the count.
- R6: A ping (`ping_i` high for one cycle) makes every bit of `poke_o` high in the next cycle and reloads every core's count.
- R7: On a ping, a core with `en_mask_o` bit 0 is re-enabled only if the reload count is nonzero or countdown mode is off.
- R8: Any change of `cd_en_i` performs a ping in which countdown mode counts as off, so every core is re-enabled. When the input is turned on, countdown mode takes effect from the following cycle.
- R9: Completion of a configuration search performs a ping with the new reload count and the current mode.
- R10: A ping in the same cycle as an interrupt edge takes priority; the edge is discarded.
- R11: Interrupts are edge-sensitive: a level held high for several cycles yields a single poke.
- R12: After reset, `poke_o` is 0, `en_mask_o` is all ones, `period_o` is 1, all counts and the reload count are 0, and countdown mode is off.
- R13: A configuration load with `heartbeat_i` = 0 is ignored: period and reload keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_load_i | input | 1 | Start period search with current heartbeat and maximum |
| heartbeat_i | input | SEC_W | Requested heartbeat, seconds |
| max_period_i | input | SEC_W | Longest base period allowed, seconds (0 counts as 1) |
| cd_en_i | input | 1 | Countdown mode level |
| ping_i | input | 1 | Keep-alive ping pulse |
| irq_i | input | N_CORES | Per-core watchdog interrupt |
| poke_o | output | N_CORES | Per-core poke pulse to the watchdog |
| en_mask_o | output | N_CORES | Per-core interrupt-response enable |
| period_o | output | SEC_W | Chosen base period, seconds |

## Verification
The hardest state to reach from the ports is a core that is silenced while the reload count is zero and countdown mode is on. In that state a ping must leave the core silenced, and only a mode change or a configuration with more periods may wake it. The bench reaches this state in steps. It loads a ten-second heartbeat, which gives a reload of zero. It exhausts a core with an interrupt, pings, and then walks out of the state both ways. Ping/interrupt priority is made visible by landing the two in one cycle after a partial countdown, then counting the pokes that follow.

// File: rtl/hbx_pkg.sv
package hbx_pkg;
  typedef enum logic {S_IDLE, S_SEARCH} search_st_e;
endpackage

// File: rtl/hbx_period_search.sv
module hbx_period_search
  import hbx_pkg::*;
#(
  parameter int SEC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [SEC_W-1:0] heartbeat_i,
  input  logic [SEC_W-1:0] max_period_i,
  output logic [SEC_W-1:0] period_o,
  output logic [SEC_W-1:0] reload_o,
  output logic             done_o
);
  search_st_e       st_q;
  logic [SEC_W-1:0] hb_q, cand_q, period_q, reload_q;
  logic             done_q;
  logic [SEC_W-1:0] max_eff, start, rem, quo;

  assign max_eff = (max_period_i == '0) ? SEC_W'(1) : max_period_i;
  assign start   = (max_eff > heartbeat_i) ? heartbeat_i : max_eff;
  assign rem     = hb_q % cand_q;
  assign quo     = hb_q / cand_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= S_IDLE;
      hb_q     <= SEC_W'(1);
      cand_q   <= SEC_W'(1);
      period_q <= SEC_W'(1);
      reload_q <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load_i && heartbeat_i != '0) begin
        st_q   <= S_SEARCH;
        hb_q   <= heartbeat_i;
        cand_q <= start;
      end else if (st_q == S_SEARCH) begin
        if (rem == '0) begin
          period_q <= cand_q;
          reload_q <= (quo > SEC_W'(2)) ? quo - SEC_W'(2) : '0;
          done_q   <= 1'b1;
          st_q     <= S_IDLE;
        end else begin
          cand_q <= cand_q - SEC_W'(1);
        end
      end
    end
  end

  assign period_o = period_q;
  assign reload_o = reload_q;
  assign done_o   = done_q;

  // R1
  period_divides_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (period_q != '0) && ((hb_q % period_q) == '0));
  // R2
  reload_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (reload_q < hb_q));
  // R13
  zero_load_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && heartbeat_i == '0 && st_q == S_IDLE) |=> $stable(period_q) && $stable(reload_q));
endmodule

// File: rtl/hbx_core_ctl.sv
module hbx_core_ctl #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             irq_i,
  input  logic             ping_i,
  input  logic             reen_ok_i,
  input  logic             mode_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic             poke_o,
  output logic             en_o
);
  logic             irq_q, poke_q, en_q, rise;
  logic [CNT_W-1:0] cnt_q;

  assign rise = irq_i & ~irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q  <= 1'b0;
      poke_q <= 1'b0;
      en_q   <= 1'b1;
      cnt_q  <= '0;
    end else begin
      irq_q  <= irq_i;
      poke_q <= 1'b0;
      if (ping_i) begin
        poke_q <= 1'b1;
        cnt_q  <= reload_i;
        if (!en_q && reen_ok_i) en_q <= 1'b1;
      end else if (rise && en_q) begin
        if (!mode_i) begin
          poke_q <= 1'b1;
        end else if (cnt_q != '0) begin
          poke_q <= 1'b1;
          cnt_q  <= cnt_q - CNT_W'(1);
        end else begin
          en_q <= 1'b0;
        end
      end
    end
  end

  assign poke_o = poke_q;
  assign en_o   = en_q;

  // R4
  silent_when_disabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ping_i && !en_q) |=> !poke_q);
  // R4
  disable_only_at_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(en_q) |-> ($past(cnt_q) == '0) && $past(mode_i));
  // R3
  count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ping_i && !rise) |=> $stable(cnt_q));
  // R11
  no_poke_without_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ping_i && !rise) |=> !poke_q);
endmodule

// File: rtl/hb_extender.sv
module hb_extender #(
  parameter int N_CORES = 4,
  parameter int SEC_W   = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_load_i,
  input  logic [SEC_W-1:0]   heartbeat_i,
  input  logic [SEC_W-1:0]   max_period_i,
  input  logic               cd_en_i,
  input  logic               ping_i,
  input  logic [N_CORES-1:0] irq_i,
  output logic [N_CORES-1:0] poke_o,
  output logic [N_CORES-1:0] en_mask_o,
  output logic [SEC_W-1:0]   period_o
);
  localparam int CNT_W = SEC_W;

  logic             mode_q, mode_edge, eff_mode, cfg_done, ping_all, reen_ok;
  logic [CNT_W-1:0] reload;

  hbx_period_search #(.SEC_W(SEC_W)) u_search (
    .clk_i, .rst_ni,
    .load_i       (cfg_load_i),
    .heartbeat_i  (heartbeat_i),
    .max_period_i (max_period_i),
    .period_o     (period_o),
    .reload_o     (reload),
    .done_o       (cfg_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= 1'b0;
    else         mode_q <= cd_en_i;
  end

  // mode change pings with countdown treated as off
  assign mode_edge = cd_en_i ^ mode_q;
  assign eff_mode  = mode_edge ? 1'b0 : mode_q;
  assign ping_all  = ping_i | mode_edge | cfg_done;
  assign reen_ok   = (reload != '0) | ~eff_mode;

  for (genvar c = 0; c < N_CORES; c++) begin : g_core
    hbx_core_ctl #(.CNT_W(CNT_W)) u_core (
      .clk_i, .rst_ni,
      .irq_i     (irq_i[c]),
      .ping_i    (ping_all),
      .reen_ok_i (reen_ok),
      .mode_i    (mode_q),
      .reload_i  (reload),
      .poke_o    (poke_o[c]),
      .en_o      (en_mask_o[c])
    );
  end

  // R6
  ping_pokes_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ping_i |=> (&poke_o));
  // R8
  mode_change_reenables_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_edge |=> (&poke_o) && (&en_mask_o));
  // R7
  no_wake_at_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ping_all && !mode_edge && mode_q && reload == '0) |=> (en_mask_o == $past(en_mask_o)));
endmodule

// File: tb/hb_extender_tb.sv
module hb_extender_tb;
  localparam int N = 4;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_load = 1'b0;
  logic [W-1:0] hb = '0, maxp = '0;
  logic         cd_en = 1'b0, ping = 1'b0;
  logic [N-1:0] irq = '0;
  logic [N-1:0] poke, en_mask;
  logic [W-1:0] period;
  int total = 0, fails = 0;

  always #2 clk = ~clk;

  hb_extender #(.N_CORES(N), .SEC_W(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_load_i(cfg_load), .heartbeat_i(hb),
    .max_period_i(maxp), .cd_en_i(cd_en), .ping_i(ping), .irq_i(irq),
    .poke_o(poke), .en_mask_o(en_mask), .period_o(period)
  );

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic configure(int h, int m);
    @(negedge clk); hb = W'(h); maxp = W'(m); cfg_load = 1'b1;
    @(negedge clk); cfg_load = 1'b0;
    repeat (300) @(negedge clk);
  endtask

  task automatic pulse_irq(int c, output logic p);
    @(negedge clk); irq[c] = 1'b1;
    @(negedge clk); p = poke[c]; irq[c] = 1'b0;
    @(negedge clk);
  endtask

  task automatic count_pokes(int c, output int n);
    logic p;
    n = 0;
    for (int i = 0; i < 20; i++) begin
      pulse_irq(c, p);
      if (!p) break;
      n++;
    end
  endtask

  task automatic do_ping(string req);
    @(negedge clk); ping = 1'b1;
    @(negedge clk); ping = 1'b0;
    check(req, int'(poke), (1 << N) - 1);
    @(negedge clk);
  endtask

  task automatic set_mode(logic v, string req);
    @(negedge clk); cd_en = v;
    @(negedge clk);
    check(req, int'(poke), (1 << N) - 1);
    check(req, int'(en_mask), (1 << N) - 1);
    @(negedge clk);
  endtask

  task automatic t_reset;
    check("R12 poke", int'(poke), 0);
    check("R12 en_mask", int'(en_mask), 15);
    check("R12 period", int'(period), 1);
  endtask

  task automatic t_config;
    configure(60, 5); check("R1 60/5", int'(period), 5);
    configure(7, 5);  check("R1 7/5", int'(period), 1);
    configure(12, 0); check("R1 max0", int'(period), 1);
    configure(4, 5);  check("R1 4/5", int'(period), 4);
    configure(0, 5);  check("R13 hb0", int'(period), 4);
  endtask

  task automatic t_always_poke;
    logic p;
    int n;
    for (int i = 0; i < 3; i++) begin
      pulse_irq(1, p); check("R5 poke mode off", int'(p), 1);
    end
    check("R5 en kept", int'(en_mask), 15);
    n = 0;
    @(negedge clk); irq[2] = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); if (poke[2]) n++;
    end
    irq[2] = 1'b0; @(negedge clk);
    check("R11 held level", n, 1);
  endtask

  task automatic t_countdown;
    logic p;
    int n;
    configure(25, 5);
    set_mode(1'b1, "R8 mode on ping");
    count_pokes(0, n);
    check("R2 R3 pokes before silence", n, 3);
    check("R4 en cleared", int'(en_mask[0]), 0);
    pulse_irq(0, p); check("R4 silent core", int'(p), 0);
    pulse_irq(1, p); check("R3 other core", int'(p), 1);
  endtask

  task automatic t_ping;
    int n;
    do_ping("R6 ping pokes");
    check("R7 reenable", int'(en_mask), 15);
    count_pokes(1, n); check("R6 reload", n, 3);
  endtask

  task automatic t_priority;
    logic p;
    int n;
    do_ping("R6 ping pokes");
    pulse_irq(0, p); check("R3 first", int'(p), 1);
    @(negedge clk); ping = 1'b1; irq[0] = 1'b1;
    @(negedge clk); ping = 1'b0; check("R10 poke", int'(poke), 15);
    irq[0] = 1'b0; @(negedge clk);
    count_pokes(0, n); check("R10 count reloaded", n, 3);
  endtask

  task automatic t_zero_reload;
    logic p;
    configure(10, 5);
    check("R1 10/5", int'(period), 5);
    check("R9 stays off at zero reload", int'(en_mask[0]), 0);
    pulse_irq(2, p); check("R2 clamp zero", int'(p), 0);
    check("R4 core2 off", int'(en_mask[2]), 0);
    do_ping("R6 ping pokes");
    check("R7 no wake", int'(en_mask), 4'b1010);
    set_mode(1'b0, "R8 mode off ping");
  endtask

  task automatic t_cfg_wake;
    logic p;
    int n;
    set_mode(1'b1, "R8 mode on ping");
    pulse_irq(3, p); check("R4 core3 silenced", int'(p), 0);
    check("R4 en3", int'(en_mask[3]), 0);
    configure(25, 5);
    check("R9 cfg reenable", int'(en_mask), 15);
    count_pokes(3, n); check("R9 cfg reload", n, 3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_config();
    t_always_poke();
    t_countdown();
    t_ping();
    t_priority();
    t_zero_reload();
    t_cfg_wake();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule